// File: doc/BRIEF.md
# Sample Output Formatter with Test Patterns

This block sits between a converter's raw sample path and its parallel output pins. Each sample clock it accepts an unsigned, offset-binary sample together with an over-range flag. It registers a formatted word onto the output bus one clock later. A two-bit pattern select can replace the live sample with a constant low word, a constant high word, or a word whose bits all flip on every sample. A two-bit format select chooses the number format and the clock edge on which a receiver should capture the data.

Patterns are defined in offset binary and go through the same conversion as live data. Selecting two's complement therefore turns every pattern into its signed equivalent, with only the top bit flipped. When the power-down input is high, the data and over-range outputs freeze at their last values and the toggle pattern stops advancing. When power-down ends, the toggle sequence resumes from the point where it stopped.

Top module: `fmt_outfmt`

## Requirements
- R1: While reset is asserted, `dout_o`, `ovr_o` and `fall_edge_o` are all 0.
- R2: With pattern select 2'b00, format bit 0 low and power-down low, `dout_o` equals the `raw_i` value seen at the previous rising clock edge, and `ovr_o` equals the previous `ovr_i`.
- R3: Pattern select 2'b01 makes the offset-binary output word all zeros.
- R4: Pattern select 2'b10 makes the offset-binary output word all ones.
- R5: Pattern select 2'b11 makes every data bit flip on each sample. The first sample after the mode is entered is all zeros.
- R6: Format select bit 0 high selects two's complement. The output is then the offset-binary word (live or pattern) with its MSB inverted, so the constant patterns become 0x800 and 0x7FF for 12 bits.
- R7: `fall_edge_o` equals format select bit 1 as seen at the previous clock edge. The encodings are 00 offset/rising, 01 two's/rising, 10 offset/falling and 11 two's/falling.
- R8: While `pdn_i` is 1, `dout_o` and `ovr_o` keep their values, whatever the other inputs do.
- R9: The toggle state does not advance during power-down. After power-down ends, the toggle sequence continues from the state it had when power-down began.
- R10: While any test pattern is selected (pattern select not 2'b00), `ovr_o` is 0 on the next sample, even when `ovr_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_i | input | 12 | Raw sample, offset binary |
| ovr_i | input | 1 | Over-range flag of the raw sample |
| tp_sel_i | input | 2 | Pattern select: 00 live, 01 zeros, 10 ones, 11 toggle |
| pdn_i | input | 1 | Power-down: hold outputs, freeze toggle |
| fmt_sel_i | input | 2 | Bit 0: two's complement; bit 1: data valid on falling edge |
| dout_o | output | 12 | Registered output word |
| ovr_o | output | 1 | Registered over-range output |
| fall_edge_o | output | 1 | Registered polarity flag, 1 means capture on falling edge |

## Verification
Two pairs of functions can act in the same cycle. Pattern substitution and two's-complement conversion combine on one sample, and the bench checks the constant and toggle patterns with format bit 0 high against the MSB-flipped words. The toggle pattern and power-down also interact: the bench enters power-down in the middle of a toggle run while changing the raw input and the over-range flag. It then expects the held word to stay put and the first sample after release to be the state that was frozen. Re-entering the toggle mode from live data must restart the sequence at all zeros.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

   typedef enum logic [1:0] {
      TP_LIVE   = 2'b00,
      TP_ZERO   = 2'b01,
      TP_ONE    = 2'b10,
      TP_TOGGLE = 2'b11
   } tp_mode_e;

   function automatic logic fmt_is_twos(input logic [1:0] sel);
      return sel[0];
   endfunction

   function automatic logic fmt_is_fall(input logic [1:0] sel);
      return sel[1];
   endfunction

endpackage

// File: rtl/fmt_pattern_gen.sv
module fmt_pattern_gen
   import fmt_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance_i,
   input  tp_mode_e          mode_i,
   input  logic [DATA_W-1:0] raw_i,
   input  logic              ovr_i,
   output logic [DATA_W-1:0] word_o,
   output logic              ovr_o
);

   logic tog_q;

   // toggle phase: cleared whenever another mode runs, frozen when not advancing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
      end else if (advance_i) begin
         tog_q <= (mode_i == TP_TOGGLE) ? ~tog_q : 1'b0;
      end
   end

   always_comb begin
      ovr_o = 1'b0;
      unique case (mode_i)
         TP_LIVE: begin
            word_o = raw_i;
            ovr_o  = ovr_i;
         end
         TP_ZERO:   word_o = '0;
         TP_ONE:    word_o = '1;
         TP_TOGGLE: word_o = {DATA_W{tog_q}};
         default:   word_o = raw_i;
      endcase
   end

endmodule

// File: rtl/fmt_code_conv.sv
module fmt_code_conv #(
   parameter int DATA_W = 12
) (
   input  logic              twos_i,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] word_o
);

   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("fmt_code_conv: DATA_W must be at least 2");
      end else begin : g_msb_flip
         assign word_o = {word_i[MSB] ^ twos_i, word_i[MSB-1:0]};
      end
   endgenerate

endmodule

// File: rtl/fmt_out_reg.sv
module fmt_out_reg #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic              ovr_i,
   input  logic              fall_i,
   output logic [DATA_W-1:0] word_o,
   output logic              ovr_o,
   output logic              fall_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= '0;
         ovr_o  <= 1'b0;
      end else if (load_i) begin
         word_o <= word_i;
         ovr_o  <= ovr_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fall_o <= 1'b0;
      end else begin
         fall_o <= fall_i;
      end
   end

endmodule

// File: rtl/fmt_outfmt.sv
module fmt_outfmt
   import fmt_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] raw_i,
   input  logic              ovr_i,
   input  logic [1:0]        tp_sel_i,
   input  logic              pdn_i,
   input  logic [1:0]        fmt_sel_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              ovr_o,
   output logic              fall_edge_o
);

   logic [DATA_W-1:0] pat_word;
   logic [DATA_W-1:0] conv_word;
   logic              pat_ovr;
   logic              run;

   assign run = ~pdn_i;

   fmt_pattern_gen #(.DATA_W(DATA_W)) u_pat (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (run),
      .mode_i    (tp_mode_e'(tp_sel_i)),
      .raw_i     (raw_i),
      .ovr_i     (ovr_i),
      .word_o    (pat_word),
      .ovr_o     (pat_ovr)
   );

   fmt_code_conv #(.DATA_W(DATA_W)) u_conv (
      .twos_i (fmt_is_twos(fmt_sel_i)),
      .word_i (pat_word),
      .word_o (conv_word)
   );

   fmt_out_reg #(.DATA_W(DATA_W)) u_oreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (run),
      .word_i (conv_word),
      .ovr_i  (pat_ovr),
      .fall_i (fmt_is_fall(fmt_sel_i)),
      .word_o (dout_o),
      .ovr_o  (ovr_o),
      .fall_o (fall_edge_o)
   );

endmodule

// File: rtl/fmt_outfmt_chk.sv
module fmt_outfmt_chk #(
   parameter int DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] raw_i,
   input logic              ovr_i,
   input logic [1:0]        tp_sel_i,
   input logic              pdn_i,
   input logic [1:0]        fmt_sel_i,
   input logic [DATA_W-1:0] dout_o,
   input logic              ovr_o,
   input logic              fall_edge_o
);

   localparam int MSB = DATA_W - 1;

   // R2
   live_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_i && tp_sel_i == 2'b00 && !fmt_sel_i[0])
      |=> (dout_o == $past(raw_i) && ovr_o == $past(ovr_i)));

   // R3
   zero_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_i && tp_sel_i == 2'b01 && !fmt_sel_i[0]) |=> (dout_o == '0));

   // R4
   ones_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_i && tp_sel_i == 2'b10 && !fmt_sel_i[0]) |=> (dout_o == '1));

   // R6
   live_twos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_i && tp_sel_i == 2'b00 && fmt_sel_i[0])
      |=> (dout_o[MSB] != $past(raw_i[MSB]) && dout_o[MSB-1:0] == $past(raw_i[MSB-1:0])));

   // R7
   polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fall_edge_o == $past(fmt_sel_i[1])));

   // R8
   pdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pdn_i |=> ($stable(dout_o) && $stable(ovr_o)));

   // R10
   pat_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_i && tp_sel_i != 2'b00) |=> !ovr_o);

endmodule

bind fmt_outfmt fmt_outfmt_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/fmt_outfmt_bench.sv
module fmt_outfmt_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] raw_i;
   logic        ovr_i;
   logic [1:0]  tp_sel_i;
   logic        pdn_i;
   logic [1:0]  fmt_sel_i;
   logic [11:0] dout_o;
   logic        ovr_o;
   logic        fall_edge_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   fmt_outfmt #(.DATA_W(12)) u_fmt_outfmt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_i), .ovr_i(ovr_i),
      .tp_sel_i(tp_sel_i), .pdn_i(pdn_i), .fmt_sel_i(fmt_sel_i),
      .dout_o(dout_o), .ovr_o(ovr_o), .fall_edge_o(fall_edge_o)
   );

   task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
      end
   endtask

   // one sample: inputs are set after a falling edge, outputs read at the next falling edge
   task automatic step(input logic [11:0] raw, input logic ovr, input logic [1:0] tp,
                       input logic pdn, input logic [1:0] fmt);
      raw_i = raw; ovr_i = ovr; tp_sel_i = tp; pdn_i = pdn; fmt_sel_i = fmt;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      raw_i = 12'hFFF; ovr_i = 1'b1; tp_sel_i = 2'b00; pdn_i = 1'b0; fmt_sel_i = 2'b11;
      repeat (3) @(negedge clk);
      chk("R1 dout", dout_o, 12'h000);
      chk("R1 ovr", {11'd0, ovr_o}, 12'd0);
      chk("R1 fall", {11'd0, fall_edge_o}, 12'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_live();
      step(12'h123, 1'b1, 2'b00, 1'b0, 2'b00);
      chk("R2 dout", dout_o, 12'h123);
      chk("R2 ovr", {11'd0, ovr_o}, 12'd1);
      step(12'hABC, 1'b0, 2'b00, 1'b0, 2'b00);
      chk("R2 dout", dout_o, 12'hABC);
      chk("R7 rising", {11'd0, fall_edge_o}, 12'd0);
   endtask

   task automatic t_twos();
      step(12'h123, 1'b0, 2'b00, 1'b0, 2'b01);
      chk("R6 live", dout_o, 12'h923);
      step(12'hABC, 1'b0, 2'b00, 1'b0, 2'b01);
      chk("R6 live", dout_o, 12'h2BC);
      step(12'h555, 1'b0, 2'b00, 1'b0, 2'b10);
      chk("R7 falling", {11'd0, fall_edge_o}, 12'd1);
   endtask

   task automatic t_patterns();
      step(12'h5A5, 1'b1, 2'b01, 1'b0, 2'b00);
      chk("R3 zeros", dout_o, 12'h000);
      chk("R10 ovr", {11'd0, ovr_o}, 12'd0);
      step(12'h5A5, 1'b1, 2'b10, 1'b0, 2'b00);
      chk("R4 ones", dout_o, 12'hFFF);
      chk("R10 ovr", {11'd0, ovr_o}, 12'd0);
      step(12'h5A5, 1'b0, 2'b01, 1'b0, 2'b01);
      chk("R6 zeros", dout_o, 12'h800);
      step(12'h5A5, 1'b0, 2'b10, 1'b0, 2'b11);
      chk("R6 ones", dout_o, 12'h7FF);
      chk("R7 falling", {11'd0, fall_edge_o}, 12'd1);
   endtask

   task automatic t_toggle();
      step(12'h111, 1'b0, 2'b00, 1'b0, 2'b00);
      step(12'h111, 1'b1, 2'b11, 1'b0, 2'b00);
      chk("R5 first", dout_o, 12'h000);
      chk("R10 ovr", {11'd0, ovr_o}, 12'd0);
      step(12'h111, 1'b0, 2'b11, 1'b0, 2'b00);
      chk("R5 second", dout_o, 12'hFFF);
      step(12'h111, 1'b0, 2'b11, 1'b0, 2'b01);
      chk("R5 R6 third", dout_o, 12'h800);
      step(12'h111, 1'b0, 2'b11, 1'b0, 2'b01);
      chk("R5 R6 fourth", dout_o, 12'h7FF);
   endtask

   task automatic t_pdn();
      step(12'h456, 1'b1, 2'b00, 1'b0, 2'b00);
      chk("R2 before pdn", dout_o, 12'h456);
      step(12'h789, 1'b0, 2'b10, 1'b1, 2'b01);
      chk("R8 hold", dout_o, 12'h456);
      chk("R8 ovr hold", {11'd0, ovr_o}, 12'd1);
      // toggle run interrupted by power-down
      step(12'h000, 1'b0, 2'b11, 1'b0, 2'b00);
      chk("R5 restart", dout_o, 12'h000);
      step(12'h000, 1'b0, 2'b11, 1'b0, 2'b00);
      chk("R5 next", dout_o, 12'hFFF);
      step(12'hABC, 1'b1, 2'b11, 1'b1, 2'b00);
      step(12'h321, 1'b1, 2'b11, 1'b1, 2'b00);
      chk("R8 toggle hold", dout_o, 12'hFFF);
      step(12'h000, 1'b0, 2'b11, 1'b0, 2'b00);
      chk("R9 resume", dout_o, 12'h000);
      step(12'h000, 1'b0, 2'b11, 1'b0, 2'b00);
      chk("R9 continue", dout_o, 12'hFFF);
   endtask

   initial begin
      t_reset();
      t_live();
      t_twos();
      t_patterns();
      t_toggle();
      t_pdn();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule